// File: doc/BRIEF.md
# Four-Stripe Request Router

This block sits between eight processor-core request ports and four independent bus stripes, each of which feeds its own downstream cache pipeline. Every master can reach every stripe. For each request the router computes a stripe index from the address, arbitrates per stripe among the masters aiming at it, forwards the winner with its master index as a tag, and routes the returned response back to that master alone.

Two mapping modes exist. In line-interleave mode, consecutive 32-byte lines rotate across the stripes. In region mode, each stripe owns a base/mask window, so software can link each partition into memory served by a private stripe. Because each stripe has its own arbiter and holds one transaction at a time, traffic on one stripe never waits on another.

Configuration writes go to a staging copy. The staged values are applied only once every stripe is idle, and no new grant is issued while a change is pending. Each master keeps at most one request outstanding and waits for its response before issuing again. Responses are always accepted by the master.

Top module: `stripe_router`

## Requirements
- R1: Each stripe carries at most one outstanding transaction. After a request is accepted on a stripe (valid and ready high at a clock edge), that stripe offers no new request until the response carrying the owner's tag has been seen.
- R2: In line-interleave mode (mode bit 0), the stripe index is address bits [6:5].
- R3: In region mode (mode bit 1), an address that satisfies (addr & mask_s) == (base_s & mask_s) for a nonzero mask_s goes to stripe s.
- R4: In region mode, an address matching several windows goes to the lowest-numbered stripe. An address matching none falls back to bits [6:5].
- R5: Each stripe arbitrates round-robin. After granting master m, the search for the next grant starts at master m+1 and wraps modulo 8. After reset the search starts at master 0.
- R6: A forwarded request carries its master index on that stripe's id output. A response is delivered only to the master whose index was stored for that stripe, as a one-cycle pulse with the stripe's read data.
- R7: A request to an idle stripe is granted, and its response returned, regardless of transactions outstanding on other stripes.
- R8: Configuration writes are staged. They take effect in the cycle after all stripes are idle. While any write is pending, no stripe issues a new request.
- R9: After reset, no stripe request is valid, no master sees ready or a response, the mode is line-interleave and every mask is zero (every window disabled).
- R10: Configuration addresses: 0 is the mode (data bit 0), 1+s is base_s, and 5+s is mask_s, for s = 0..3.
- R11: Ready goes only to a master that is presenting a request. Each stripe acceptance consumes exactly one master request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Configuration write strobe |
| cfg_addr_i | input | 4 | Configuration register select |
| cfg_wdata_i | input | 32 | Configuration write data |
| mst_req_valid_i | input | 8 | Request valid, one bit per master |
| mst_req_ready_o | output | 8 | Request accepted, one bit per master |
| mst_req_addr_i | input | 256 | Request address, 32 bits per master |
| mst_req_we_i | input | 8 | Request is a write, per master |
| mst_req_wdata_i | input | 256 | Write data, 32 bits per master |
| mst_rsp_valid_o | output | 8 | Response pulse, per master |
| mst_rsp_rdata_o | output | 256 | Response data, 32 bits per master |
| str_req_valid_o | output | 4 | Request valid, per stripe |
| str_req_ready_i | input | 4 | Stripe accepts request |
| str_req_addr_o | output | 128 | Forwarded address, 32 bits per stripe |
| str_req_we_o | output | 4 | Forwarded write flag, per stripe |
| str_req_wdata_o | output | 128 | Forwarded write data, 32 bits per stripe |
| str_req_id_o | output | 12 | Master tag, 3 bits per stripe |
| str_rsp_valid_i | input | 4 | Response valid, per stripe |
| str_rsp_id_i | input | 12 | Response tag, 3 bits per stripe |
| str_rsp_rdata_i | input | 128 | Response data, 32 bits per stripe |

## Verification
A configuration change can collide with live traffic: a mode write lands while one stripe still holds a long transaction, and in the same stretch a second master presents an address whose stripe differs between the old and new maps. The bench provokes this by writing the mode a few cycles after a slow transfer starts and issuing the second request right after the write. The result is judged by which stripe serves the second request (read data encodes the stripe) and by that request being accepted only after the slow stripe's response cycle. Simultaneous round-robin contention and cross-stripe overlap are also staged with per-stripe latencies chosen by the bench.

// File: rtl/stripe_pkg.sv
`timescale 1ns/100ps
package stripe_pkg;
  typedef enum logic {MAP_LINE = 1'b0, MAP_REGION = 1'b1} map_mode_e;
  localparam int unsigned CFG_MODE_ADDR = 0;
  localparam int unsigned CFG_BASE_ADDR = 1;
  localparam int unsigned CFG_MASK_ADDR = 5;
endpackage

// File: rtl/stripe_cfg.sv
`timescale 1ns/100ps
module stripe_cfg
  import stripe_pkg::*;
#(
  parameter int unsigned AW     = 32,
  parameter int unsigned N_STR  = 4,
  parameter int unsigned CFG_AW = 4
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic                          cfg_we_i,
  input  logic [CFG_AW-1:0]             cfg_addr_i,
  input  logic [AW-1:0]                 cfg_wdata_i,
  input  logic                          idle_i,
  output map_mode_e                     mode_o,
  output logic [N_STR-1:0][AW-1:0]      base_o,
  output logic [N_STR-1:0][AW-1:0]      mask_o,
  output logic                          pend_o
);
  map_mode_e                sh_mode, act_mode;
  logic [N_STR-1:0][AW-1:0] sh_base, sh_mask, act_base, act_mask;
  logic                     pend_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sh_mode  <= MAP_LINE;
      act_mode <= MAP_LINE;
      sh_base  <= '0;
      sh_mask  <= '0;
      act_base <= '0;
      act_mask <= '0;
      pend_q   <= 1'b0;
    end else if (cfg_we_i) begin
      pend_q <= 1'b1;
      if (cfg_addr_i == CFG_AW'(CFG_MODE_ADDR)) sh_mode <= map_mode_e'(cfg_wdata_i[0]);
      for (int s = 0; s < N_STR; s++) begin
        if (cfg_addr_i == CFG_AW'(CFG_BASE_ADDR + s)) sh_base[s] <= cfg_wdata_i;
        if (cfg_addr_i == CFG_AW'(CFG_MASK_ADDR + s)) sh_mask[s] <= cfg_wdata_i;
      end
    end else if (pend_q && idle_i) begin
      act_mode <= sh_mode;
      act_base <= sh_base;
      act_mask <= sh_mask;
      pend_q   <= 1'b0;
    end
  end

  assign mode_o = act_mode;
  assign base_o = act_base;
  assign mask_o = act_mask;
  assign pend_o = pend_q;
endmodule

// File: rtl/stripe_map.sv
`timescale 1ns/100ps
module stripe_map
  import stripe_pkg::*;
#(
  parameter int unsigned AW       = 32,
  parameter int unsigned N_STR    = 4,
  parameter int unsigned LINE_LSB = 5,
  localparam int unsigned SIDW    = $clog2(N_STR)
) (
  input  logic [AW-1:0]            addr_i,
  input  map_mode_e                mode_i,
  input  logic [N_STR-1:0][AW-1:0] base_i,
  input  logic [N_STR-1:0][AW-1:0] mask_i,
  output logic [SIDW-1:0]          sel_o
);
  logic [SIDW-1:0] line_sel, reg_sel;
  logic            reg_hit;

  assign line_sel = addr_i[LINE_LSB +: SIDW];

  // scan downward so the lowest matching stripe is the last one written
  always_comb begin
    reg_hit = 1'b0;
    reg_sel = '0;
    for (int s = N_STR - 1; s >= 0; s--) begin
      if (|mask_i[s] && ((addr_i & mask_i[s]) == (base_i[s] & mask_i[s]))) begin
        reg_hit = 1'b1;
        reg_sel = SIDW'(s);
      end
    end
  end

  assign sel_o = (mode_i == MAP_REGION && reg_hit) ? reg_sel : line_sel;
endmodule

// File: rtl/stripe_arb.sv
`timescale 1ns/100ps
module stripe_arb #(
  parameter int unsigned N_MST = 8,
  localparam int unsigned MIDW = $clog2(N_MST)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [N_MST-1:0]  req_i,
  input  logic              allow_i,
  input  logic              ready_i,
  input  logic              done_i,
  output logic              gnt_valid_o,
  output logic [MIDW-1:0]   gnt_id_o,
  output logic              busy_o,
  output logic [MIDW-1:0]   owner_o
);
  logic [MIDW-1:0] ptr_q, owner_q, pick;
  logic            busy_q, found;

  always_comb begin
    pick  = '0;
    found = 1'b0;
    for (int k = 0; k < N_MST; k++) begin
      int unsigned j;
      j = (int'(ptr_q) + k) % N_MST;
      if (!found && req_i[j]) begin
        pick  = MIDW'(j);
        found = 1'b1;
      end
    end
  end

  assign gnt_valid_o = !busy_q && allow_i && found;
  assign gnt_id_o    = pick;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q  <= 1'b0;
      owner_q <= '0;
      ptr_q   <= '0;
    end else if (gnt_valid_o && ready_i) begin
      busy_q  <= 1'b1;
      owner_q <= pick;
      ptr_q   <= MIDW'((int'(pick) + 1) % N_MST);
    end else if (busy_q && done_i) begin
      busy_q <= 1'b0;
    end
  end

  assign busy_o  = busy_q;
  assign owner_o = owner_q;
endmodule

// File: rtl/stripe_router.sv
`timescale 1ns/100ps
module stripe_router
  import stripe_pkg::*;
#(
  parameter int unsigned N_MST    = 8,
  parameter int unsigned N_STR    = 4,
  parameter int unsigned AW       = 32,
  parameter int unsigned DW       = 32,
  parameter int unsigned LINE_LSB = 5,
  parameter int unsigned CFG_AW   = 4,
  localparam int unsigned MIDW    = $clog2(N_MST),
  localparam int unsigned SIDW    = $clog2(N_STR)
) (
  input  logic                  clk_i,
  input  logic                  rst_ni,
  input  logic                  cfg_we_i,
  input  logic [CFG_AW-1:0]     cfg_addr_i,
  input  logic [AW-1:0]         cfg_wdata_i,
  input  logic [N_MST-1:0]      mst_req_valid_i,
  output logic [N_MST-1:0]      mst_req_ready_o,
  input  logic [N_MST*AW-1:0]   mst_req_addr_i,
  input  logic [N_MST-1:0]      mst_req_we_i,
  input  logic [N_MST*DW-1:0]   mst_req_wdata_i,
  output logic [N_MST-1:0]      mst_rsp_valid_o,
  output logic [N_MST*DW-1:0]   mst_rsp_rdata_o,
  output logic [N_STR-1:0]      str_req_valid_o,
  input  logic [N_STR-1:0]      str_req_ready_i,
  output logic [N_STR*AW-1:0]   str_req_addr_o,
  output logic [N_STR-1:0]      str_req_we_o,
  output logic [N_STR*DW-1:0]   str_req_wdata_o,
  output logic [N_STR*MIDW-1:0] str_req_id_o,
  input  logic [N_STR-1:0]      str_rsp_valid_i,
  input  logic [N_STR*MIDW-1:0] str_rsp_id_i,
  input  logic [N_STR*DW-1:0]   str_rsp_rdata_i
);
  map_mode_e                   mode;
  logic [N_STR-1:0][AW-1:0]    base, mask;
  logic                        cfg_pend;
  logic [N_MST-1:0][SIDW-1:0]  m_sel;
  logic [N_STR-1:0][N_MST-1:0] s_req;
  logic [N_STR-1:0]            s_gv, s_busy, s_done;
  logic [N_STR-1:0][MIDW-1:0]  s_gid, s_own;

  stripe_cfg #(.AW(AW), .N_STR(N_STR), .CFG_AW(CFG_AW)) u_cfg (
    .clk_i, .rst_ni, .cfg_we_i, .cfg_addr_i, .cfg_wdata_i,
    .idle_i (~|s_busy),
    .mode_o (mode),
    .base_o (base),
    .mask_o (mask),
    .pend_o (cfg_pend)
  );

  for (genvar m = 0; m < N_MST; m++) begin : g_map
    stripe_map #(.AW(AW), .N_STR(N_STR), .LINE_LSB(LINE_LSB)) u_map (
      .addr_i (mst_req_addr_i[m*AW +: AW]),
      .mode_i (mode),
      .base_i (base),
      .mask_i (mask),
      .sel_o  (m_sel[m])
    );
  end

  always_comb begin
    for (int s = 0; s < N_STR; s++)
      for (int m = 0; m < N_MST; m++)
        s_req[s][m] = mst_req_valid_i[m] && (m_sel[m] == SIDW'(s));
  end

  for (genvar s = 0; s < N_STR; s++) begin : g_str
    assign s_done[s] = str_rsp_valid_i[s] && (str_rsp_id_i[s*MIDW +: MIDW] == s_own[s]);

    stripe_arb #(.N_MST(N_MST)) u_arb (
      .clk_i, .rst_ni,
      .req_i       (s_req[s]),
      .allow_i     (!cfg_pend),
      .ready_i     (str_req_ready_i[s]),
      .done_i      (s_done[s]),
      .gnt_valid_o (s_gv[s]),
      .gnt_id_o    (s_gid[s]),
      .busy_o      (s_busy[s]),
      .owner_o     (s_own[s])
    );

    assign str_req_valid_o[s]              = s_gv[s];
    assign str_req_addr_o[s*AW +: AW]      = mst_req_addr_i[int'(s_gid[s])*AW +: AW];
    assign str_req_we_o[s]                 = mst_req_we_i[s_gid[s]];
    assign str_req_wdata_o[s*DW +: DW]     = mst_req_wdata_i[int'(s_gid[s])*DW +: DW];
    assign str_req_id_o[s*MIDW +: MIDW]    = s_gid[s];
  end

  always_comb begin
    mst_req_ready_o = '0;
    mst_rsp_valid_o = '0;
    mst_rsp_rdata_o = '0;
    for (int s = 0; s < N_STR; s++) begin
      if (s_gv[s] && str_req_ready_i[s]) mst_req_ready_o[s_gid[s]] = 1'b1;
      if (s_busy[s] && s_done[s]) begin
        mst_rsp_valid_o[s_own[s]] = 1'b1;
        mst_rsp_rdata_o[int'(s_own[s])*DW +: DW] = str_rsp_rdata_i[s*DW +: DW];
      end
    end
  end
endmodule

// File: rtl/stripe_router_chk.sv
`timescale 1ns/100ps
module stripe_router_chk #(
  parameter int unsigned N_MST = 8,
  parameter int unsigned N_STR = 4
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic [N_MST-1:0] mst_req_valid_i,
  input logic [N_MST-1:0] mst_req_ready_o,
  input logic [N_MST-1:0] mst_rsp_valid_o,
  input logic [N_STR-1:0] str_req_valid_o,
  input logic [N_STR-1:0] str_req_ready_i,
  input logic [N_STR-1:0] str_rsp_valid_i,
  input logic             cfg_pend
);
  for (genvar s = 0; s < N_STR; s++) begin : g_s
    assert_hold_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (str_req_valid_o[s] && str_req_ready_i[s]) |=> !str_req_valid_o[s])
      else $error("stripe %0d offered a second request while busy", s);
  end

  assert_block_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    cfg_pend |-> (str_req_valid_o == '0))
    else $error("grant issued during pending configuration");

  assert_ready_valid_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mst_req_ready_o & ~mst_req_valid_i) == '0)
    else $error("ready to idle master");

  assert_fire_match_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mst_req_valid_i & mst_req_ready_o) == $countones(str_req_valid_o & str_req_ready_i))
    else $error("master and stripe acceptances disagree");

  assert_rsp_count_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(mst_rsp_valid_o) <= $countones(str_rsp_valid_i))
    else $error("more master responses than stripe responses");
endmodule

bind stripe_router stripe_router_chk #(.N_MST(N_MST), .N_STR(N_STR)) chk_i (.*);

// File: tb/stripe_router_tb_top.sv
`timescale 1ns/100ps
module stripe_router_tb_top;
  localparam int NM = 8, NS = 4, AW = 32, DW = 32, IW = 3;

  logic clk = 1'b0, rst_n = 1'b0;
  always #2 clk = ~clk;

  logic              cfg_we = 1'b0;
  logic [3:0]        cfg_addr = '0;
  logic [AW-1:0]     cfg_wdata = '0;
  logic [NM-1:0]     m_valid = '0, m_ready, m_we = '0, r_valid;
  logic [NM*AW-1:0]  m_addr = '0;
  logic [NM*DW-1:0]  m_wdata = '0, r_rdata;
  logic [NS-1:0]     s_valid, s_ready = '1, s_we, s_rvalid = '0;
  logic [NS*AW-1:0]  s_addr;
  logic [NS*DW-1:0]  s_wdata, s_rdata = '0;
  logic [NS*IW-1:0]  s_id, s_rid = '0;

  stripe_router dut_i (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_addr_i(cfg_addr), .cfg_wdata_i(cfg_wdata),
    .mst_req_valid_i(m_valid), .mst_req_ready_o(m_ready), .mst_req_addr_i(m_addr),
    .mst_req_we_i(m_we), .mst_req_wdata_i(m_wdata),
    .mst_rsp_valid_o(r_valid), .mst_rsp_rdata_o(r_rdata),
    .str_req_valid_o(s_valid), .str_req_ready_i(s_ready), .str_req_addr_o(s_addr),
    .str_req_we_o(s_we), .str_req_wdata_o(s_wdata), .str_req_id_o(s_id),
    .str_rsp_valid_i(s_rvalid), .str_rsp_id_i(s_rid), .str_rsp_rdata_i(s_rdata)
  );

  int n_chk = 0, n_bad = 0, cyc = 0, n_xfer = 0, n_rsp = 0;
  int hold_viol = 0, rdy_viol = 0;
  int lat [NS] = '{2, 2, 2, 2};
  logic       sm_busy [NS] = '{default: 1'b0};
  int         sm_cnt  [NS];
  logic [2:0] sm_id   [NS];
  logic [31:0] sm_addr [NS];
  int         rsp_cyc [NS];
  int         log_n   [NS] = '{default: 0};
  int         log_id  [NS][64];

  initial forever begin @(posedge clk); cyc++; end

  // stripe models: act half a unit after the falling edge
  initial forever begin
    @(negedge clk); #0.5;
    for (int s = 0; s < NS; s++) begin
      if (s_rvalid[s]) s_rvalid[s] = 1'b0;
      if (sm_busy[s] && s_valid[s]) hold_viol++;
      if (sm_busy[s]) begin
        if (sm_cnt[s] <= 1) begin
          s_rvalid[s] = 1'b1;
          s_rid[s*IW +: IW] = sm_id[s];
          s_rdata[s*DW +: DW] = sm_addr[s] ^ (32'(s) << 28);
          sm_busy[s] = 1'b0;
          rsp_cyc[s] = cyc;
        end else sm_cnt[s]--;
      end else if (s_valid[s]) begin
        sm_busy[s] = 1'b1;
        sm_cnt[s]  = lat[s];
        sm_id[s]   = s_id[s*IW +: IW];
        sm_addr[s] = s_addr[s*AW +: AW];
        if (log_n[s] < 64) log_id[s][log_n[s]] = int'(s_id[s*IW +: IW]);
        log_n[s]++;
      end
    end
  end

  initial forever begin
    @(negedge clk); #1.5;
    n_rsp += $countones(r_valid);
    if ((m_ready & ~m_valid) != '0) rdy_viol++;
  end

  task automatic check(input bit ok, input string tag, input longint act, input longint exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic xfer(input int m, input logic [31:0] a, output logic [31:0] d,
                      output int iss_c, output int acc_c, output int rsp_c);
    @(negedge clk);
    m_valid[m] = 1'b1;
    m_addr[m*AW +: AW] = a;
    iss_c = cyc;
    #1;
    while (!m_ready[m]) begin @(negedge clk); #1; end
    acc_c = cyc;
    @(negedge clk);
    m_valid[m] = 1'b0;
    #1;
    while (!r_valid[m]) begin @(negedge clk); #1; end
    d = r_rdata[m*DW +: DW];
    rsp_c = cyc;
    n_xfer++;
  endtask

  function automatic int stripe_of(input logic [31:0] a, input logic [31:0] d);
    return ((a ^ d) & 32'h0FFF_FFFF) == 0 ? int'((a ^ d) >> 28) : -1;
  endfunction

  task automatic cfg_write(input int adr, input logic [31:0] v);
    @(negedge clk);
    cfg_we = 1'b1; cfg_addr = 4'(adr); cfg_wdata = v;
    @(negedge clk);
    cfg_we = 1'b0;
  endtask

  task automatic t_reset();
    #1;
    check(s_valid == '0, "R9 stripe valid at reset", s_valid, 0);
    check(m_ready == '0, "R9 master ready at reset", m_ready, 0);
    check(r_valid == '0, "R9 response at reset", r_valid, 0);
  endtask

  task automatic go(input int m, input logic [31:0] a, input int exp_s, input string tag);
    logic [31:0] d; int i0, a0, r0;
    xfer(m, a, d, i0, a0, r0);
    check(stripe_of(a, d) == exp_s, tag, stripe_of(a, d), exp_s);
  endtask

  task automatic t_line();
    // default mode after reset is interleave with no windows (R9)
    go(0, 32'h0000_0000, 0, "R2 line 0");
    go(0, 32'h0000_0020, 1, "R2 line 1");
    go(0, 32'h0000_0040, 2, "R2 line 2");
    go(0, 32'h0000_0060, 3, "R2 line 3");
    go(0, 32'h0000_0080, 0, "R2 wrap line 4");
    go(7, 32'h1234_5140, 2, "R9 interleave after reset, bits 6:5");
  endtask

  task automatic t_region();
    int n1;
    cfg_write(2, 32'h1000_0000);
    cfg_write(6, 32'hFF00_0000);
    cfg_write(3, 32'h1000_0000);
    cfg_write(7, 32'hF000_0000);
    cfg_write(0, 32'h1);
    n1 = log_n[1];
    go(4, 32'h1000_0040, 1, "R4 overlap takes lowest stripe");
    check(log_id[1][n1] == 4, "R6 request tag on stripe", log_id[1][n1], 4);
    go(4, 32'h1100_0060, 2, "R3 single window match");
    go(4, 32'h2000_0020, 1, "R4 no match falls back to line");
    go(5, 32'h1000_0000, 1, "R10 base1/mask1 at addresses 2 and 6");
  endtask

  task automatic t_rr();
    int n0;
    lat[0] = 6;
    go(5, 32'h0000_0000, 0, "R5 single grant");
    n0 = log_n[0];
    fork
      go(1, 32'h0000_0080, 0, "R5 contender 1");
      go(3, 32'h0000_0100, 0, "R5 contender 3");
      go(6, 32'h0000_0180, 0, "R5 contender 6");
    join
    check(log_id[0][n0]   == 6, "R5 first after 5", log_id[0][n0], 6);
    check(log_id[0][n0+1] == 1, "R5 wrap to 1", log_id[0][n0+1], 1);
    check(log_id[0][n0+2] == 3, "R5 then 3", log_id[0][n0+2], 3);
    lat[0] = 2;
  endtask

  task automatic t_iso();
    logic [31:0] d0, d2; int i0, a0, r0, i2, a2, r2;
    lat[0] = 40;
    fork
      xfer(0, 32'h0000_0200, d0, i0, a0, r0);
      begin
        repeat (3) @(negedge clk);
        xfer(2, 32'h0000_0020, d2, i2, a2, r2);
      end
    join
    check(a2 - i2 <= 1, "R7 grant while other stripe busy", a2 - i2, 1);
    check(r2 - a2 <= lat[1] + 2, "R7 response latency", r2 - a2, lat[1] + 2);
    check(r2 < r0, "R7 returns before slow stripe", r2, r0);
    check(stripe_of(32'h0000_0020, d2) == 1, "R6 data to own master", stripe_of(32'h0000_0020, d2), 1);
    lat[0] = 2;
  endtask

  task automatic t_cfg();
    logic [31:0] d0, d1; int i0, a0, r0, i1, a1, r1;
    lat[3] = 30;
    fork
      xfer(0, 32'h0000_0060, d0, i0, a0, r0);
      begin
        repeat (3) @(negedge clk);
        cfg_write(0, 32'h0);
        xfer(1, 32'h1100_0000, d1, i1, a1, r1);
      end
    join
    check(stripe_of(32'h0000_0060, d0) == 3, "R8 in-flight on old map", stripe_of(32'h0000_0060, d0), 3);
    check(stripe_of(32'h1100_0000, d1) == 0, "R8 new map after drain", stripe_of(32'h1100_0000, d1), 0);
    check(a1 > r0, "R8 grant blocked until drained", a1, r0);
    lat[3] = 2;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    t_reset();
    rst_n = 1'b1;
    t_line();
    t_region();
    t_rr();
    t_iso();
    t_cfg();
    repeat (4) @(negedge clk);
    check(hold_viol == 0, "R1 one outstanding per stripe", hold_viol, 0);
    check(n_rsp == n_xfer, "R6 one response per transfer", n_rsp, n_xfer);
    check(rdy_viol == 0, "R11 ready only with valid", rdy_viol, 0);
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    n_chk++; n_bad++;
    $display("FAIL watchdog actual=hung expected=done");
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end
endmodule